// File: doc/BRIEF.md
# Fast Ethernet PCS Receive Code-Group Decoder

This block sits between a code-group aligner (already descrambled) and the MAC-side receive interface of a 100 Mb/s physical layer. It accepts one 5-bit code-group per handshake and turns the stream back into nibbles. It tracks frame boundaries: a /J/K/ pair opens a frame and an /T/R/ pair closes it. For each accepted code-group it produces one output beat that carries a frame-valid flag, an error flag and a nibble. The frame-valid flag and the nibble feed the MAC's receive data valid and receive data; the error flag feeds its receive error line.

The `err_mode` input selects how the error flag behaves. With `err_mode` at 0 it follows conventional Fast Ethernet receive signalling. That covers false carrier, a bad start or end delimiter, idle arriving mid-frame, misplaced control code-groups and invalid code-groups. With `err_mode` at 1 the flag rises only for a code-group that is not one of the sixteen data codes or the I, J, K, T, R control codes. This gives a quick count of line bit errors. The bit is applied to each code-group as it is accepted.

Both data sides use valid/ready. The input is accepted on a rising clock edge when `cg_valid` and `cg_ready` are both high. The resulting beat appears on the output in the following cycle. `cg_ready` is high whenever the output register is empty or `rx_ready` is high. While `rx_valid` is high and `rx_ready` is low, the output beat is held unchanged and no new code-group is accepted. Frame tracking advances only on accepted code-groups.

Top module: `pcs_rx_decoder`

## Requirements
- R1: While `rst_n` is low, and after its release until the first code-group is accepted, `rx_valid`, `rx_dv` and `rx_er` are 0 and `cg_ready` is 1.
- R2: Each accepted code-group gives exactly one output beat, with `rx_valid` high in the cycle after acceptance. While `rx_valid` is high and `rx_ready` is low, `cg_ready` is 0 and `rx_nib`, `rx_dv` and `rx_er` hold their values.
- R3: Outside a frame, J (11000) gives a beat with dv=1, er=0, nibble 0101. A K (10001) accepted right after that J gives dv=1, er=0, nibble 0101, and the frame is open.
- R4: Inside a frame, a data code-group gives dv=1, er=0 and its nibble. The code to nibble pairs are: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F.
- R5: Inside a frame, T (01101) gives dv=0, er=0, nibble 0000. A following R (00111) gives the same beat and closes the frame. After that, dv stays 0 until a new J.
- R6: Outside a frame, idle (11111) gives dv=0, er=0, nibble 0000, in both modes.
- R7: An invalid code-group (any code other than the sixteen data codes and I, J, K, T, R) inside a frame gives dv=1, er=1, nibble 0000 in both modes, and the frame stays open.
- R8: Outside a frame, with `err_mode`=0, any code-group other than I or J gives dv=0, er=1, nibble 1110 (false carrier). With `err_mode`=1 it gives dv=0, nibble 0000, and er=1 only if the code-group is invalid.
- R9: A J not followed by K ends the attempt. The beat for the second code-group has dv=0 and nibble 1110 with er=1 when `err_mode`=0. With `err_mode`=1 it has nibble 0000 and er set only if that code-group is invalid.
- R10: Idle accepted inside a frame gives dv=0, nibble 0000 and closes the frame. er is 1 with `err_mode`=0 and 0 with `err_mode`=1.
- R11: J, K or R accepted inside a frame gives dv=1, nibble 0000 and keeps the frame open. er is 1 with `err_mode`=0 and 0 with `err_mode`=1.
- R12: A T followed by anything other than R closes the frame with a dv=0, nibble 0000 beat. er is 1 with `err_mode`=0; with `err_mode`=1, er is set only for an invalid code-group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_mode | input | 1 | 0: conventional error signalling, 1: flag invalid code-groups only |
| cg_valid | input | 1 | Code-group present on `cg_data` |
| cg_ready | output | 1 | Decoder can accept a code-group |
| cg_data | input | 5 | Aligned, descrambled code-group |
| rx_valid | output | 1 | Output beat present |
| rx_ready | input | 1 | Consumer takes the output beat |
| rx_dv | output | 1 | Receive data valid for this beat |
| rx_er | output | 1 | Receive error for this beat |
| rx_nib | output | 4 | Decoded nibble for this beat |

## Verification
The assertions assume that `err_mode` does not change between acceptance of a code-group and the appearance of its beat. They also assume that `cg_data` is a full 5-bit code-group whenever `cg_valid` is high. The bench changes `err_mode` only while no code-group is in flight, and it drives code-groups taken from the code lists in the requirements. Invalid patterns are injected deliberately to reach the error paths. Back-pressure is applied only by holding `rx_ready` low while a beat is waiting, which is the condition the hold property describes.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;
  localparam int CG_W  = 5;
  localparam int NIB_W = 4;

  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CG_W-1:0] CG_J    = 5'b11000;
  localparam logic [CG_W-1:0] CG_K    = 5'b10001;
  localparam logic [CG_W-1:0] CG_T    = 5'b01101;
  localparam logic [CG_W-1:0] CG_R    = 5'b00111;

  localparam logic [NIB_W-1:0] NIB_PRE = 4'b0101;
  localparam logic [NIB_W-1:0] NIB_FC  = 4'b1110;

  typedef enum logic [2:0] {
    CL_DATA, CL_IDLE, CL_J, CL_K, CL_T, CL_R, CL_BAD
  } cg_class_e;

  typedef struct packed {
    logic              dv;
    logic              er;
    logic [NIB_W-1:0]  nib;
  } beat_t;

  localparam int BEAT_W = $bits(beat_t);

  // Inverse 4B/5B data mapping; valid flag low for non-data codes.
  function automatic logic [NIB_W:0] data_lookup(input logic [CG_W-1:0] c);
    logic [NIB_W:0] r;
    case (c)
      5'b11110: r = {1'b1, 4'h0};
      5'b01001: r = {1'b1, 4'h1};
      5'b10100: r = {1'b1, 4'h2};
      5'b10101: r = {1'b1, 4'h3};
      5'b01010: r = {1'b1, 4'h4};
      5'b01011: r = {1'b1, 4'h5};
      5'b01110: r = {1'b1, 4'h6};
      5'b01111: r = {1'b1, 4'h7};
      5'b10010: r = {1'b1, 4'h8};
      5'b10011: r = {1'b1, 4'h9};
      5'b10110: r = {1'b1, 4'hA};
      5'b10111: r = {1'b1, 4'hB};
      5'b11010: r = {1'b1, 4'hC};
      5'b11011: r = {1'b1, 4'hD};
      5'b11100: r = {1'b1, 4'hE};
      5'b11101: r = {1'b1, 4'hF};
      default:  r = '0;
    endcase
    return r;
  endfunction

  function automatic logic cg_is_invalid(input logic [CG_W-1:0] c);
    logic [NIB_W:0] d;
    d = data_lookup(c);
    return !(d[NIB_W] || c == CG_IDLE || c == CG_J || c == CG_K ||
             c == CG_T || c == CG_R);
  endfunction
endpackage

// File: rtl/pcs_rx_classify.sv
module pcs_rx_classify
  import pcs_rx_pkg::*;
(
  input  logic [CG_W-1:0]  cg,
  output cg_class_e        cls,
  output logic [NIB_W-1:0] nib
);
  logic [NIB_W:0] look;

  always_comb begin
    look = data_lookup(cg);
    nib  = look[NIB_W-1:0];
    if (look[NIB_W])        cls = CL_DATA;
    else if (cg == CG_IDLE) cls = CL_IDLE;
    else if (cg == CG_J)    cls = CL_J;
    else if (cg == CG_K)    cls = CL_K;
    else if (cg == CG_T)    cls = CL_T;
    else if (cg == CG_R)    cls = CL_R;
    else                    cls = CL_BAD;
  end
endmodule

// File: rtl/pcs_rx_fsm.sv
module pcs_rx_fsm
  import pcs_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             sym_only,
  input  cg_class_e        cls,
  input  logic [NIB_W-1:0] nib,
  output beat_t            beat
);
  typedef enum logic [1:0] {ST_IDLE, ST_GOT_J, ST_DATA, ST_GOT_T} st_e;

  st_e  st, st_nxt;
  logic inv;
  logic std;
  logic [NIB_W-1:0] abort_nib;
  logic abort_er;

  always_comb begin
    inv       = (cls == CL_BAD);
    std       = !sym_only;
    abort_nib = std ? NIB_FC : '0;
    abort_er  = std | inv;
    st_nxt    = st;
    beat      = '0;
    case (st)
      ST_IDLE: begin
        if (cls == CL_J) begin
          beat   = '{dv: 1'b1, er: 1'b0, nib: NIB_PRE};
          st_nxt = ST_GOT_J;
        end else if (cls != CL_IDLE) begin
          beat = '{dv: 1'b0, er: abort_er, nib: abort_nib};
        end
      end
      ST_GOT_J: begin
        if (cls == CL_K) begin
          beat   = '{dv: 1'b1, er: 1'b0, nib: NIB_PRE};
          st_nxt = ST_DATA;
        end else begin
          beat   = '{dv: 1'b0, er: abort_er, nib: abort_nib};
          st_nxt = ST_IDLE;
        end
      end
      ST_DATA: begin
        case (cls)
          CL_DATA: beat = '{dv: 1'b1, er: 1'b0, nib: nib};
          CL_T: begin
            beat   = '0;
            st_nxt = ST_GOT_T;
          end
          CL_IDLE: begin
            beat   = '{dv: 1'b0, er: std, nib: '0};
            st_nxt = ST_IDLE;
          end
          CL_BAD:  beat = '{dv: 1'b1, er: 1'b1, nib: '0};
          default: beat = '{dv: 1'b1, er: std, nib: '0};
        endcase
      end
      default: begin
        st_nxt = ST_IDLE;
        if (cls == CL_R) beat = '0;
        else             beat = '{dv: 1'b0, er: abort_er, nib: '0};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st <= ST_IDLE;
    else if (adv) st <= st_nxt;
  end
endmodule

// File: rtl/pcs_rx_outreg.sv
module pcs_rx_outreg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/pcs_rx_decoder.sv
module pcs_rx_decoder
  import pcs_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_mode,
  input  logic             cg_valid,
  output logic             cg_ready,
  input  logic [CG_W-1:0]  cg_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             rx_dv,
  output logic             rx_er,
  output logic [NIB_W-1:0] rx_nib
);
  cg_class_e        cls;
  logic [NIB_W-1:0] dnib;
  beat_t            beat_in;
  beat_t            beat_out;
  logic             adv;

  assign adv = cg_valid && cg_ready;

  pcs_rx_classify u_cls (
    .cg  (cg_data),
    .cls (cls),
    .nib (dnib)
  );

  pcs_rx_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .sym_only (err_mode),
    .cls      (cls),
    .nib      (dnib),
    .beat     (beat_in)
  );

  pcs_rx_outreg #(.W(BEAT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (cg_valid),
    .in_ready  (cg_ready),
    .in_data   (beat_in),
    .out_valid (rx_valid),
    .out_ready (rx_ready),
    .out_data  (beat_out)
  );

  assign rx_dv  = beat_out.dv;
  assign rx_er  = beat_out.er;
  assign rx_nib = beat_out.nib;
endmodule

// File: rtl/pcs_rx_checker.sv
module pcs_rx_checker
  import pcs_rx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             err_mode,
  input logic             cg_valid,
  input logic             cg_ready,
  input logic [CG_W-1:0]  cg_data,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             rx_dv,
  input logic             rx_er,
  input logic [NIB_W-1:0] rx_nib
);
  logic acc;
  assign acc = cg_valid && cg_ready;

  // R2: stalled beat is held
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_nib) && $stable(rx_dv) && $stable(rx_er));

  // R2: an accepted code-group always yields a beat
  a_r2_beat: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rx_valid);

  // R2: a taken beat with no new input empties the output
  a_r2_drain: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !cg_valid |=> !rx_valid);

  // R6: idle never produces data valid
  a_r6_idle_no_dv: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cg_data == CG_IDLE |=> !rx_dv);

  // R7: invalid code-groups are flagged in both modes
  a_r7_invalid_flag: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cg_is_invalid(cg_data) |=> rx_er);

  // R8: in symbol-error mode a defined code-group never raises the error flag
  a_r8_symmode_clean: assert property (@(posedge clk) disable iff (!rst_n)
    acc && err_mode && !cg_is_invalid(cg_data) |=> !rx_er);
endmodule

bind pcs_rx_decoder pcs_rx_checker u_pcs_rx_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .err_mode (err_mode),
  .cg_valid (cg_valid),
  .cg_ready (cg_ready),
  .cg_data  (cg_data),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rx_dv    (rx_dv),
  .rx_er    (rx_er),
  .rx_nib   (rx_nib)
);

// File: tb/pcs_rx_decoder_bench.sv
module pcs_rx_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       err_mode = 1'b0;
  logic       cg_valid = 1'b0;
  logic       cg_ready;
  logic [4:0] cg_data = 5'b11111;
  logic       rx_valid;
  logic       rx_ready = 1'b1;
  logic       rx_dv;
  logic       rx_er;
  logic [3:0] rx_nib;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  localparam logic [4:0] I = 5'b11111, J = 5'b11000, K = 5'b10001,
                         T = 5'b01101, R = 5'b00111;
  localparam logic [4:0] BAD0 = 5'b00000, BAD1 = 5'b00100;

  always #10 clk = ~clk;

  pcs_rx_decoder u_pcs_rx_decoder (
    .clk(clk), .rst_n(rst_n), .err_mode(err_mode),
    .cg_valid(cg_valid), .cg_ready(cg_ready), .cg_data(cg_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_dv(rx_dv), .rx_er(rx_er), .rx_nib(rx_nib)
  );

  function automatic logic [4:0] enc(input int n);
    case (n)
      0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;  3: return 5'b10101;
      4: return 5'b01010;  5: return 5'b01011;  6: return 5'b01110;  7: return 5'b01111;
      8: return 5'b10010;  9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
      12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got {valid,dv,er,nib}=%b expected %b", req, act, exp);
    end
  endtask

  // drive one code-group, then check its beat
  task automatic step(input logic [4:0] c, input logic dv, input logic er,
                      input logic [3:0] nib, input string req);
    @(negedge clk);
    cg_valid = 1'b1;
    cg_data  = c;
    @(negedge clk);
    check(req, {rx_valid, rx_dv, rx_er, rx_nib}, {1'b1, dv, er, nib});
    cg_valid = 1'b0;
  endtask

  task automatic open_frame(input string req);
    step(J, 1, 0, 4'b0101, req);
    step(K, 1, 0, 4'b0101, req);
  endtask

  task automatic close_frame(input string req);
    step(T, 0, 0, 4'h0, req);
    step(R, 0, 0, 4'h0, req);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", {rx_valid, rx_dv, rx_er, 4'h0}, 7'b0);
    total++;
    if (cg_ready !== 1'b1) begin bad++; $display("FAIL R1: cg_ready=%b expected 1", cg_ready); end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {rx_valid, rx_dv, rx_er, 4'h0}, 7'b0);
  endtask

  task automatic t_frame;
    err_mode = 1'b0;
    step(I, 0, 0, 4'h0, "R6");
    open_frame("R3");
    for (int n = 0; n < 16; n++) step(enc(n), 1, 0, n[3:0], "R4");
    close_frame("R5");
    step(I, 0, 0, 4'h0, "R5");
    step(enc(3), 0, 1, 4'b1110, "R5");
  endtask

  task automatic t_false_carrier;
    err_mode = 1'b0;
    step(enc(5), 0, 1, 4'b1110, "R8");
    step(BAD0, 0, 1, 4'b1110, "R8");
    err_mode = 1'b1;
    step(enc(5), 0, 0, 4'h0, "R8");
    step(BAD0, 0, 1, 4'h0, "R8");
    step(I, 0, 0, 4'h0, "R6");
  endtask

  task automatic t_bad_ssd;
    err_mode = 1'b0;
    step(J, 1, 0, 4'b0101, "R9");
    step(enc(2), 0, 1, 4'b1110, "R9");
    step(enc(2), 0, 1, 4'b1110, "R9");
    err_mode = 1'b1;
    step(J, 1, 0, 4'b0101, "R9");
    step(enc(2), 0, 0, 4'h0, "R9");
    step(J, 1, 0, 4'b0101, "R9");
    step(BAD1, 0, 1, 4'h0, "R9");
    step(I, 0, 0, 4'h0, "R9");
  endtask

  task automatic t_invalid_in_frame;
    for (int m = 0; m < 2; m++) begin
      err_mode = m[0];
      open_frame("R7");
      step(enc(9), 1, 0, 4'h9, "R7");
      step(BAD0, 1, 1, 4'h0, "R7");
      step(enc(10), 1, 0, 4'hA, "R7");
      close_frame("R7");
    end
  endtask

  task automatic t_premature_idle;
    for (int m = 0; m < 2; m++) begin
      err_mode = m[0];
      open_frame("R10");
      step(enc(1), 1, 0, 4'h1, "R10");
      step(I, 0, !m[0], 4'h0, "R10");
      step(enc(1), 0, !m[0], m[0] ? 4'h0 : 4'b1110, "R10");
    end
  endtask

  task automatic t_misplaced;
    for (int m = 0; m < 2; m++) begin
      err_mode = m[0];
      open_frame("R11");
      step(K, 1, !m[0], 4'h0, "R11");
      step(R, 1, !m[0], 4'h0, "R11");
      step(J, 1, !m[0], 4'h0, "R11");
      step(enc(7), 1, 0, 4'h7, "R11");
      close_frame("R11");
    end
  endtask

  task automatic t_bad_esd;
    err_mode = 1'b0;
    open_frame("R12");
    step(T, 0, 0, 4'h0, "R12");
    step(enc(4), 0, 1, 4'h0, "R12");
    step(I, 0, 0, 4'h0, "R12");
    err_mode = 1'b1;
    open_frame("R12");
    step(T, 0, 0, 4'h0, "R12");
    step(enc(4), 0, 0, 4'h0, "R12");
    open_frame("R12");
    step(T, 0, 0, 4'h0, "R12");
    step(BAD1, 0, 1, 4'h0, "R12");
    step(enc(4), 0, 0, 4'h0, "R12");
  endtask

  task automatic t_stall;
    err_mode = 1'b0;
    @(negedge clk);
    rx_ready = 1'b0;
    cg_valid = 1'b1;
    cg_data  = J;
    @(negedge clk);
    check("R2", {rx_valid, rx_dv, rx_er, rx_nib}, {3'b110, 4'b0101});
    cg_data = K;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      total++;
      if (cg_ready !== 1'b0) begin bad++; $display("FAIL R2: cg_ready=%b expected 0", cg_ready); end
      check("R2", {rx_valid, rx_dv, rx_er, rx_nib}, {3'b110, 4'b0101});
    end
    rx_ready = 1'b1;
    @(negedge clk);
    check("R2", {rx_valid, rx_dv, rx_er, rx_nib}, {3'b110, 4'b0101});
    cg_valid = 1'b0;
    @(negedge clk);
    check("R2", {rx_valid, 6'b0}, 7'b0);
    step(enc(6), 1, 0, 4'h6, "R2");
    close_frame("R2");
  endtask

  initial begin
    t_reset();
    t_frame();
    t_false_carrier();
    t_bad_ssd();
    t_invalid_in_frame();
    t_premature_idle();
    t_misplaced();
    t_bad_esd();
    t_stall();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule